// File: doc/BRIEF.md
# Serial Channel Error Injector

A synthesizable model of a bit-serial link. It sits between a serial encoder and a serial decoder and passes each bit straight through. On request, it inverts one or two chosen bit positions inside every 7-bit codeword. The encoder's ready pulse marks the first bit of each codeword, and codeword bit indices count from that pulse. The injection enable and the two position selects are captured on the ready pulse and then held for the rest of the codeword, so changes to them mid-frame do not disturb the word that is in flight.

The same hardware serves as a fault source in bring-up and as a channel model in a formal or simulation environment. With the enable low the block is a wire. With both selects equal it produces a single error, which a correcting decoder must repair. With the selects different it produces a double error, which such a decoder must not silently repair.

Top module: `chan_err_inject`

## Requirements
- R1: When the enable captured for the current codeword is 0, `ser_out` equals `ser_in` on every cycle of that codeword.
- R2: When injection is enabled and `pos_a` equals `pos_b` (value 0..6), exactly one bit of the codeword is inverted: the bit at that index. Index 0 is the bit present in the cycle where `enc_ready` is 1, and index k is the bit k cycles later.
- R3: When injection is enabled and `pos_a` and `pos_b` are different values in 0..6, exactly the two bits at those indices are inverted.
- R4: `inj_en`, `pos_a` and `pos_b` are used as they stand in the `enc_ready` cycle. Changes to them in later cycles of the same codeword have no effect on `ser_out`.
- R5: After reset, and before the first `enc_ready`, no bit is inverted, whatever the values on `inj_en` and the selects.
- R6: The bit index runs 0..6 from each `enc_ready`. Bits that arrive after index 6 and before the next `enc_ready` pass through unchanged.
- R7: A select value of 7 selects no bit. With one select at 7, only the other select's bit is inverted.
- R8: The data path adds no delay: each output bit is the input bit of the same cycle, inverted or not.
- R9: An `enc_ready` in the middle of a codeword restarts the index at 0 and captures the controls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial bit from the encoder |
| enc_ready | input | 1 | High in the cycle that carries bit 0 of a codeword |
| inj_en | input | 1 | Error injection enable, captured on enc_ready |
| pos_a | input | 3 | First error bit index (0..6), captured on enc_ready |
| pos_b | input | 3 | Second error bit index (0..6), captured on enc_ready |
| ser_out | output | 1 | Serial bit delivered to the decoder |

## Verification
The bench aims at the off-by-one traps at both ends of the codeword.

- Indices 0 and 6 are both exercised. A counter that started at 1, or that counted the ready cycle twice, would corrupt a neighbouring bit.
- A tail of bits after index 6 is driven. A counter that wrapped instead of stopping would corrupt bits outside any frame.
- Select and enable changes are made right after the ready cycle. A design that read the live controls would flip the wrong bits.
- A ready pulse is given in mid-frame, a select value of 7 is used, and bits are driven straight after reset. These catch a design that ignores the restart, one that aliases index 7 onto the idle state, and one that injects errors from a stale enable.

// File: rtl/chan_inj_pkg.sv
package chan_inj_pkg;

  localparam int DEF_FRAME_LEN = 7;
  localparam int NUM_SEL = 2;

  // True when a select value names a bit that exists in the frame and
  // equals the current bit index.
  function automatic bit pos_hit(input int idx, input int pos, input int frame_len);
    return (pos < frame_len) && (idx == pos);
  endfunction

  // Next value of the bit index while a frame is active.
  function automatic int idx_step(input int idx);
    return idx + 1;
  endfunction

endpackage

// File: rtl/chan_bit_index.sv
module chan_bit_index #(
  parameter int FRAME_LEN = 7,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [IDX_W-1:0] cur_idx,
  output logic             in_frame
);
  import chan_inj_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [IDX_W-1:0] cnt_q;
  logic             act_q;

  // The start cycle is index 0 by itself; the register holds the index of
  // the next cycle.
  assign cur_idx  = start ? '0 : cnt_q;
  assign in_frame = start | act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start) begin
      cnt_q <= IDX_W'(1);
      act_q <= (FRAME_LEN > 1);
    end else if (act_q) begin
      if (cnt_q == LAST_IDX) begin
        act_q <= 1'b0;
      end else begin
        cnt_q <= IDX_W'(idx_step(int'(cnt_q)));
      end
    end
  end

endmodule

// File: rtl/chan_ctrl_latch.sv
module chan_ctrl_latch #(
  parameter int IDX_W = 3,
  parameter int NSEL = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic                       en_in,
  input  logic [NSEL-1:0][IDX_W-1:0] pos_in,
  output logic                       en_q,
  output logic                       en_eff,
  output logic [NSEL-1:0][IDX_W-1:0] pos_eff
);

  logic [NSEL-1:0][IDX_W-1:0] pos_q;

  // In the load cycle the live controls govern bit 0, afterwards the
  // captured copy governs the rest of the frame.
  assign en_eff  = load ? en_in : en_q;
  assign pos_eff = load ? pos_in : pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      pos_q <= '0;
    end else if (load) begin
      en_q  <= en_in;
      pos_q <= pos_in;
    end
  end

endmodule

// File: rtl/chan_flip_gen.sv
module chan_flip_gen #(
  parameter int FRAME_LEN = 7,
  parameter int IDX_W = 3,
  parameter int NSEL = 2
) (
  input  logic                       in_frame,
  input  logic [IDX_W-1:0]           cur_idx,
  input  logic                       en_eff,
  input  logic [NSEL-1:0][IDX_W-1:0] pos_eff,
  output logic [NSEL-1:0]            sel_hit,
  output logic                       flip
);
  import chan_inj_pkg::*;

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel_hit[g] = pos_hit(int'(cur_idx), int'(pos_eff[g]), FRAME_LEN);
  end

  // Equal selects hit the same index once, so a single bit is inverted.
  assign flip = en_eff & in_frame & (|sel_hit);

endmodule

// File: rtl/chan_err_inject.sv
module chan_err_inject #(
  parameter int FRAME_LEN = chan_inj_pkg::DEF_FRAME_LEN,
  localparam int IDX_W = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             enc_ready,
  input  logic             inj_en,
  input  logic [IDX_W-1:0] pos_a,
  input  logic [IDX_W-1:0] pos_b,
  output logic             ser_out
);
  import chan_inj_pkg::*;

  logic [IDX_W-1:0]                  cur_idx;
  logic                              in_frame;
  logic                              en_q;
  logic                              en_eff;
  logic [NUM_SEL-1:0][IDX_W-1:0]     pos_live;
  logic [NUM_SEL-1:0][IDX_W-1:0]     pos_eff;
  logic [NUM_SEL-1:0]                sel_hit;
  logic                              flip;

  assign pos_live[0] = pos_a;
  assign pos_live[1] = pos_b;

  chan_bit_index #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_idx (
    .clk      (clk),
    .rst      (rst),
    .start    (enc_ready),
    .cur_idx  (cur_idx),
    .in_frame (in_frame)
  );

  chan_ctrl_latch #(.IDX_W(IDX_W), .NSEL(NUM_SEL)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .load    (enc_ready),
    .en_in   (inj_en),
    .pos_in  (pos_live),
    .en_q    (en_q),
    .en_eff  (en_eff),
    .pos_eff (pos_eff)
  );

  chan_flip_gen #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W), .NSEL(NUM_SEL)) u_flip (
    .in_frame (in_frame),
    .cur_idx  (cur_idx),
    .en_eff   (en_eff),
    .pos_eff  (pos_eff),
    .sel_hit  (sel_hit),
    .flip     (flip)
  );

  assign ser_out = ser_in ^ flip;

endmodule

// File: rtl/chan_err_inject_chk.sv
module chan_err_inject_chk #(
  parameter int FRAME_LEN = 7,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             enc_ready,
  input logic             inj_en,
  input logic             ser_in,
  input logic             ser_out,
  input logic             en_q,
  input logic [IDX_W-1:0] cur_idx,
  input logic             in_frame
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  p_pass_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    (enc_ready ? !inj_en : !en_q) |-> (ser_out == ser_in));

  p_hold_ctrl_r4: assert property (@(posedge clk) disable iff (rst)
    !enc_ready |=> $stable(en_q));

  p_reset_clears_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !en_q);

  p_idx_zero_r9: assert property (@(posedge clk) disable iff (rst)
    enc_ready |-> (cur_idx == '0) && in_frame);

  p_idx_step_r6: assert property (@(posedge clk) disable iff (rst)
    in_frame && !enc_ready && (cur_idx != LAST_IDX) |=>
      enc_ready || (in_frame && (cur_idx == $past(cur_idx) + 1'b1)));

  p_frame_end_r6: assert property (@(posedge clk) disable iff (rst)
    in_frame && (cur_idx == LAST_IDX) |=> enc_ready || !in_frame);

  p_flip_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
    (ser_out != ser_in) |-> in_frame);

  p_idx_range_r7: assert property (@(posedge clk) disable iff (rst)
    in_frame |-> (cur_idx <= LAST_IDX));

endmodule

bind chan_err_inject chan_err_inject_chk #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .enc_ready (enc_ready),
  .inj_en    (inj_en),
  .ser_in    (ser_in),
  .ser_out   (ser_out),
  .en_q      (en_q),
  .cur_idx   (cur_idx),
  .in_frame  (in_frame)
);

// File: tb/tb_chan_err_inject.sv
module tb_chan_err_inject;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic       enc_ready = 1'b0;
  logic       inj_en = 1'b0;
  logic [2:0] pos_a = 3'd0;
  logic [2:0] pos_b = 3'd0;
  logic       ser_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chan_err_inject dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .enc_ready(enc_ready),
    .inj_en(inj_en), .pos_a(pos_a), .pos_b(pos_b), .ser_out(ser_out)
  );

  // Row layout: din[20:14] en[13] pos_a[12:10] pos_b[9:7] expected[6:0].
  // Bit i of a word travels at index i.
  localparam int NVEC = 8;
  localparam logic [20:0] VEC [NVEC] = '{
    {7'h59, 1'b0, 3'd3, 3'd5, 7'h59},  // R1 off
    {7'h00, 1'b1, 3'd0, 3'd0, 7'h01},  // R2 index 0
    {7'h7F, 1'b1, 3'd6, 3'd6, 7'h3F},  // R2 index 6
    {7'h2A, 1'b1, 3'd1, 3'd4, 7'h38},  // R3
    {7'h55, 1'b1, 3'd0, 3'd6, 7'h14},  // R3 both ends
    {7'h33, 1'b1, 3'd7, 3'd7, 7'h33},  // R7 none
    {7'h0F, 1'b1, 3'd7, 3'd2, 7'h0B},  // R7 one left
    {7'h60, 1'b1, 3'd5, 3'd3, 7'h48}   // R3
  };

  task automatic check(input bit ok, input string req, input logic [6:0] act, input logic [6:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sends nbits of din with a ready pulse on bit 0; from bit 1 on the
  // controls are replaced by the late values. Output is sampled in the
  // same cycle as the input bit (R8).
  task automatic send_frame(input logic [6:0] din, input logic en, input logic [2:0] a,
                            input logic [2:0] b, input logic late_en, input logic [2:0] late_a,
                            input logic [2:0] late_b, input int nbits, output logic [6:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      ser_in = din[i];
      enc_ready = (i == 0);
      if (i == 0) begin
        inj_en = en; pos_a = a; pos_b = b;
      end else begin
        inj_en = late_en; pos_a = late_a; pos_b = late_b;
      end
      #2 got[i] = ser_out;
    end
    @(negedge clk);
    enc_ready = 1'b0;
  endtask

  task automatic send_idle(input logic [6:0] din, input int nbits, output logic [6:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      if (i > 0) @(negedge clk);
      enc_ready = 1'b0;
      ser_in = din[i];
      #2 got[i] = ser_out;
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R5: enable driven high, no ready yet
    @(negedge clk);
    inj_en = 1'b1; pos_a = 3'd0; pos_b = 3'd1;
    send_idle(7'h35, 7, got);
    check(got == 7'h35, "R5 no flip before first frame", got, 7'h35);

    // Table walk: R1 R2 R3 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      logic [20:0] row;
      row = VEC[v];
      send_frame(row[20:14], row[13], row[12:10], row[9:7],
                 row[13], row[12:10], row[9:7], 7, got);
      check(got == row[6:0], "R1/R2/R3/R7/R8 table", got, row[6:0]);
    end

    // R4: captured enable on, live enable dropped and selects moved
    send_frame(7'h00, 1'b1, 3'd2, 3'd2, 1'b0, 3'd5, 3'd1, 7, got);
    check(got == 7'h04, "R4 held select", got, 7'h04);

    // R4: captured enable off, live enable raised mid-frame
    send_frame(7'h1C, 1'b0, 3'd0, 3'd0, 1'b1, 3'd3, 3'd4, 7, got);
    check(got == 7'h1C, "R4 held disable", got, 7'h1C);

    // R6: enabled frame, then a tail of bits with no ready
    send_frame(7'h00, 1'b1, 3'd0, 3'd0, 1'b1, 3'd0, 3'd0, 7, got);
    check(got == 7'h01, "R6 frame before tail", got, 7'h01);
    inj_en = 1'b1; pos_a = 3'd0; pos_b = 3'd1;
    send_idle(7'h05, 5, got);
    check(got == 7'h05, "R6 tail passes", got, 7'h05);

    // R9: restart after two bits of a frame
    send_frame(7'h00, 1'b1, 3'd3, 3'd3, 1'b1, 3'd3, 3'd3, 2, got);
    check(got == 7'h00, "R9 partial frame", got, 7'h00);
    send_frame(7'h00, 1'b1, 3'd0, 3'd0, 1'b1, 3'd0, 3'd0, 7, got);
    check(got == 7'h01, "R9 restarted index", got, 7'h01);

    // R5: reset in the middle of an enabled frame
    send_frame(7'h00, 1'b1, 3'd6, 3'd6, 1'b1, 3'd6, 3'd6, 3, got);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send_idle(7'h00, 7, got);
    check(got == 7'h00, "R5 reset clears enable", got, 7'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule